// File: doc/BRIEF.md
# LPDDR2 Power-Up Sequencer

This block is a hardware state machine. It walks a freshly reset LPDDR2 device through its bring-up. After a single start pulse it presents a fixed list of commands on a command port. It holds each command until the controller acknowledges it, and it inserts the device's mandatory waits between some of the commands. The waits are counted in clock cycles, and their lengths come from the clock frequency given as a parameter.

Alongside the commands it drives three other things. It sets the type of impedance calibration the controller should request. It opens the input buffers for the tail of the mode-register phase and closes them again. At the end it presents the refresh interval and the calibration/MR4 settings for loading, then flags completion. The block is used once per reset: a later start pulse has no effect.

Top module: `lp2_bringup_seq`

## Requirements
- R1: During reset and after it, until start, cmd_valid_o, ibuf_en_o, refresh_we_o, calmr4_we_o and done_o are 0, and zq_type_o is 2'b00 (no calibration).
- R2: cmd_mode_o encodes NORMAL as 3'd0, NOP as 3'd1 and a mode-register command as 3'd7. cmd_addr_o carries the 8-bit mode-register address of a mode-register command and is 0 otherwise.
- R3: A start pulse produces exactly 14 commands in this order: NOP, NOP, MR 63, MR 10, MR 1, MR 2, MR 3, MR 16, NOP, MR 5, MR 6, MR 8, MR 0, NORMAL.
- R4: A command stays valid, with mode and address unchanged, until the cycle in which cmd_ack_i is high. That cycle accepts it. cmd_ack_i is ignored while cmd_valid_o is low.
- R5: After a command is accepted, the block leaves these numbers of idle cycles before the next command: ceil(100 ns·f) after the first NOP, 200 µs·f after the second NOP, ceil(1 µs·f) after MR 63, and exactly one after every other command.
- R6: zq_type_o is 2'b11 (reset calibration) from the first cycle of the MR 10 command through its acceptance cycle. It is 2'b10 (short calibration) from the following cycle onward.
- R7: ibuf_en_o rises in the first cycle of the third NOP. It stays high through the cycle in which NORMAL is accepted and is low from the next cycle on.
- R8: Exactly two cycles after NORMAL is accepted, refresh_we_o and calmr4_we_o pulse together for one cycle. In that cycle refresh_val_o equals refresh_cnt_i and calmr4_val_o equals calmr4_i.
- R9: done_o rises the cycle after the load pulse and stays high until reset. No command is issued while it is high.
- R10: A start pulse while the sequence runs, or after done_o, changes nothing. Only a reset re-arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts the bring-up (first pulse after reset only) |
| refresh_cnt_i | input | REF_W | Refresh interval to load at the end |
| calmr4_i | input | CAL_W | Calibration/MR4 settings to load at the end |
| cmd_ack_i | input | 1 | Accepts the presented command |
| cmd_valid_o | output | 1 | Command present |
| cmd_mode_o | output | 3 | Command mode code |
| cmd_addr_o | output | 8 | Mode-register address |
| ibuf_en_o | output | 1 | Input-buffer enable |
| zq_type_o | output | 2 | Calibration type: 00 none, 11 reset, 10 short |
| refresh_we_o | output | 1 | Load strobe for the refresh interval |
| refresh_val_o | output | REF_W | Refresh interval to be loaded |
| calmr4_we_o | output | 1 | Load strobe for the calibration/MR4 settings |
| calmr4_val_o | output | CAL_W | Calibration/MR4 settings to be loaded |
| done_o | output | 1 | Bring-up finished |

## Verification
Two things can land on the same clock edge: the acceptance of a command, and a stray acknowledge or extra start pulse. The bench sweeps acknowledge latencies from zero to three cycles. In half of the runs it also raises the acknowledge during waits and gaps, and it pulses start in mid-sequence and after completion. Each command's mode, address, hold time and idle gap are compared with values worked out from the clock frequency. The calibration type, buffer enable, load strobes and done are compared cycle by cycle with a model that changes only on acceptance. So a stray event that advanced the sequence would show up as a wrong gap or an extra command.

// File: rtl/lp2_bringup_pkg.sv
package lp2_bringup_pkg;

   typedef enum logic [2:0] {
      CMD_NORMAL = 3'd0,
      CMD_NOP    = 3'd1,
      CMD_MRW    = 3'd7
   } cmd_mode_e;

   typedef enum logic [1:0] {
      ZQ_NONE  = 2'b00,
      ZQ_SHORT = 2'b10,
      ZQ_RESET = 2'b11
   } zq_kind_e;

   typedef enum logic [1:0] {
      DLY_NONE  = 2'd0,
      DLY_SHORT = 2'd1,
      DLY_LONG  = 2'd2,
      DLY_INIT  = 2'd3
   } dly_cls_e;

   typedef struct packed {
      cmd_mode_e  mode;
      logic [7:0] addr;
      dly_cls_e   dly;
      logic       last;
   } step_t;

   localparam int NUM_STEPS = 14;
   localparam int CAL_STEP  = 3;   // step carrying the calibration command
   localparam int BUF_STEP  = 8;   // step at which input buffers open

endpackage

// File: rtl/lp2_step_rom.sv
module lp2_step_rom
   import lp2_bringup_pkg::*;
#(
   parameter int IDX_W = 4
)(
   input  logic [IDX_W-1:0] idx_i,
   output step_t            step_o
);

   function automatic step_t mk(cmd_mode_e m, logic [7:0] a, dly_cls_e d, logic l);
      step_t s;
      s.mode = m;
      s.addr = a;
      s.dly  = d;
      s.last = l;
      return s;
   endfunction

   always_comb begin
      step_o = mk(CMD_NORMAL, 8'd0, DLY_NONE, 1'b1);
      case (idx_i)
         IDX_W'(0):  step_o = mk(CMD_NOP,    8'd0,  DLY_SHORT, 1'b0);
         IDX_W'(1):  step_o = mk(CMD_NOP,    8'd0,  DLY_LONG,  1'b0);
         IDX_W'(2):  step_o = mk(CMD_MRW,    8'd63, DLY_INIT,  1'b0);
         IDX_W'(3):  step_o = mk(CMD_MRW,    8'd10, DLY_NONE,  1'b0);
         IDX_W'(4):  step_o = mk(CMD_MRW,    8'd1,  DLY_NONE,  1'b0);
         IDX_W'(5):  step_o = mk(CMD_MRW,    8'd2,  DLY_NONE,  1'b0);
         IDX_W'(6):  step_o = mk(CMD_MRW,    8'd3,  DLY_NONE,  1'b0);
         IDX_W'(7):  step_o = mk(CMD_MRW,    8'd16, DLY_NONE,  1'b0);
         IDX_W'(8):  step_o = mk(CMD_NOP,    8'd0,  DLY_NONE,  1'b0);
         IDX_W'(9):  step_o = mk(CMD_MRW,    8'd5,  DLY_NONE,  1'b0);
         IDX_W'(10): step_o = mk(CMD_MRW,    8'd6,  DLY_NONE,  1'b0);
         IDX_W'(11): step_o = mk(CMD_MRW,    8'd8,  DLY_NONE,  1'b0);
         IDX_W'(12): step_o = mk(CMD_MRW,    8'd0,  DLY_NONE,  1'b0);
         IDX_W'(13): step_o = mk(CMD_NORMAL, 8'd0,  DLY_NONE,  1'b1);
         default:    step_o = mk(CMD_NORMAL, 8'd0,  DLY_NONE,  1'b1);
      endcase
   end

endmodule

// File: rtl/lp2_wait_timer.sv
module lp2_wait_timer #(
   parameter int CNT_W = 15
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= len_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   // last cycle of the wait: the sequencer raises the next command at this edge
   assign expire_o = (cnt_q == CNT_W'(1));

   AST_TMR_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> len_i != '0);                                                   // R5
   AST_TMR_NO_RELOAD:   assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> cnt_q == '0);                                                   // R5

endmodule

// File: rtl/lp2_seq_ctl.sv
module lp2_seq_ctl
   import lp2_bringup_pkg::*;
#(
   parameter int IDX_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ack_i,
   input  logic             last_i,
   input  logic             wait_i,
   input  logic             tmr_expire_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             tmr_load_o,
   output logic             valid_o,
   output logic             ibuf_o,
   output zq_kind_e         zq_o,
   output logic             load_o,
   output logic             done_o
);

   typedef enum logic [2:0] {
      S_IDLE, S_ISSUE, S_WAIT, S_GAP, S_CLOSE, S_LOAD, S_DONE
   } st_e;

   localparam logic [IDX_W-1:0] CAL_I = IDX_W'(CAL_STEP);
   localparam logic [IDX_W-1:0] BUF_I = IDX_W'(BUF_STEP);

   st_e              st_q;
   logic [IDX_W-1:0] nxt;
   logic             accept;
   logic             advance;

   assign nxt        = idx_o + 1'b1;
   assign accept     = (st_q == S_ISSUE) && ack_i;
   assign advance    = (st_q == S_GAP) || ((st_q == S_WAIT) && tmr_expire_i);
   assign tmr_load_o = accept && !last_i && wait_i;
   assign load_o     = (st_q == S_LOAD);
   assign done_o     = (st_q == S_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         idx_o   <= '0;
         valid_o <= 1'b0;
         ibuf_o  <= 1'b0;
         zq_o    <= ZQ_NONE;
      end else begin
         case (st_q)
            S_IDLE: if (start_i) begin
               idx_o   <= '0;
               valid_o <= 1'b1;
               st_q    <= S_ISSUE;
            end
            S_ISSUE: if (ack_i) begin
               valid_o <= 1'b0;
               if (idx_o == CAL_I) zq_o <= ZQ_SHORT;
               if (last_i) begin
                  ibuf_o <= 1'b0;
                  st_q   <= S_CLOSE;
               end else if (wait_i) begin
                  st_q   <= S_WAIT;
               end else begin
                  st_q   <= S_GAP;
               end
            end
            S_WAIT, S_GAP: if (advance) begin
               idx_o   <= nxt;
               valid_o <= 1'b1;
               st_q    <= S_ISSUE;
               if (nxt == CAL_I) zq_o   <= ZQ_RESET;
               if (nxt == BUF_I) ibuf_o <= 1'b1;
            end
            S_CLOSE: st_q <= S_LOAD;
            S_LOAD:  st_q <= S_DONE;
            default: st_q <= S_DONE;
         endcase
      end
   end

   AST_HOLD_CMD:       assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ack_i |=> valid_o && $stable(idx_o));                          // R4
   AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o);                                                      // R9
   AST_DONE_STICKS:    assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);                                                        // R9
   AST_BUF_SHUT_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> !ibuf_o);                                                       // R7
   AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(load_o));                                          // R8

endmodule

// File: rtl/lp2_bringup_seq.sv
module lp2_bringup_seq
   import lp2_bringup_pkg::*;
#(
   parameter int CLK_FREQ_MHZ = 100,
   parameter int T_SHORT_NS   = 100,
   parameter int T_LONG_US    = 200,
   parameter int T_INIT_NS    = 1000,
   parameter int REF_W        = 16,
   parameter int CAL_W        = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [REF_W-1:0] refresh_cnt_i,
   input  logic [CAL_W-1:0] calmr4_i,
   input  logic             cmd_ack_i,
   output logic             cmd_valid_o,
   output logic [2:0]       cmd_mode_o,
   output logic [7:0]       cmd_addr_o,
   output logic             ibuf_en_o,
   output logic [1:0]       zq_type_o,
   output logic             refresh_we_o,
   output logic [REF_W-1:0] refresh_val_o,
   output logic             calmr4_we_o,
   output logic [CAL_W-1:0] calmr4_val_o,
   output logic             done_o
);

   localparam int CYC_SHORT = (T_SHORT_NS * CLK_FREQ_MHZ + 999) / 1000;
   localparam int CYC_LONG  = T_LONG_US * CLK_FREQ_MHZ;
   localparam int CYC_INIT  = (T_INIT_NS * CLK_FREQ_MHZ + 999) / 1000;
   localparam int CNT_W     = $clog2(CYC_LONG + 1);
   localparam int IDX_W     = $clog2(NUM_STEPS);

   generate
      if (CLK_FREQ_MHZ < 1) begin : g_bad_freq
         $error("CLK_FREQ_MHZ must be at least 1");
      end
      if (CYC_SHORT < 1 || CYC_INIT < 1 || CYC_LONG < 1) begin : g_bad_wait
         $error("every wait must last at least one cycle");
      end
      if (REF_W < 1 || CAL_W < 1) begin : g_bad_width
         $error("load widths must be positive");
      end
   endgenerate

   step_t            step;
   logic [IDX_W-1:0] idx;
   logic             tmr_load;
   logic             tmr_expire;
   logic [CNT_W-1:0] tmr_len;
   zq_kind_e         zq;
   logic             load;

   lp2_step_rom #(.IDX_W(IDX_W)) u_rom (
      .idx_i  (idx),
      .step_o (step)
   );

   always_comb begin
      case (step.dly)
         DLY_SHORT: tmr_len = CNT_W'(CYC_SHORT);
         DLY_LONG:  tmr_len = CNT_W'(CYC_LONG);
         DLY_INIT:  tmr_len = CNT_W'(CYC_INIT);
         default:   tmr_len = CNT_W'(1);
      endcase
   end

   lp2_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .len_i    (tmr_len),
      .expire_o (tmr_expire)
   );

   lp2_seq_ctl #(.IDX_W(IDX_W)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .ack_i        (cmd_ack_i),
      .last_i       (step.last),
      .wait_i       (step.dly != DLY_NONE),
      .tmr_expire_i (tmr_expire),
      .idx_o        (idx),
      .tmr_load_o   (tmr_load),
      .valid_o      (cmd_valid_o),
      .ibuf_o       (ibuf_en_o),
      .zq_o         (zq),
      .load_o       (load),
      .done_o       (done_o)
   );

   assign cmd_mode_o    = step.mode;
   assign cmd_addr_o    = step.addr;
   assign zq_type_o     = zq;
   assign refresh_we_o  = load;
   assign calmr4_we_o   = load;
   assign refresh_val_o = refresh_cnt_i;
   assign calmr4_val_o  = calmr4_i;

   AST_ZQ_RESET_ON_CAL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && cmd_mode_o == 3'd7 && cmd_addr_o == 8'd10 |-> zq_type_o == 2'b11); // R6
   AST_BUF_SHUT_EARLY:  assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && cmd_mode_o == 3'd7 && cmd_addr_o == 8'd63 |-> !ibuf_en_o);        // R7

endmodule

// File: tb/lp2_bringup_seq_bench.sv
module lp2_bringup_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int FREQ       = 25;
   localparam int NSTEP      = 14;
   localparam int G_SHORT    = (100 * FREQ + 999) / 1000;
   localparam int G_LONG     = 200 * FREQ;
   localparam int G_INIT     = (1000 * FREQ + 999) / 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] ref_cnt = '0;
   logic [31:0] cal_cfg = '0;
   logic        ack = 1'b0;
   logic        valid, ibuf, ref_we, cal_we, done;
   logic [2:0]  mode;
   logic [7:0]  addr;
   logic [1:0]  zq;
   logic [15:0] ref_val;
   logic [31:0] cal_val;

   lp2_bringup_seq #(.CLK_FREQ_MHZ(FREQ), .REF_W(16), .CAL_W(32)) u_lp2_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .refresh_cnt_i(ref_cnt),
      .calmr4_i(cal_cfg), .cmd_ack_i(ack), .cmd_valid_o(valid), .cmd_mode_o(mode),
      .cmd_addr_o(addr), .ibuf_en_o(ibuf), .zq_type_o(zq), .refresh_we_o(ref_we),
      .refresh_val_o(ref_val), .calmr4_we_o(cal_we), .calmr4_val_o(cal_val), .done_o(done)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_mode(int i);
      if (i == 0 || i == 1 || i == 8) return 1;
      if (i == 13) return 0;
      return 7;
   endfunction

   function automatic int exp_addr(int i);
      case (i)
         2: return 63;  3: return 10;  4: return 1;  5: return 2;
         6: return 3;   7: return 16;  9: return 5;  10: return 6;
         11: return 8;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_gap(int i);
      if (i == 0) return G_SHORT;
      if (i == 1) return G_LONG;
      if (i == 2) return G_INIT;
      return 1;
   endfunction

   // monitor state
   bit mon_on = 0;
   int lat = 0;
   bit stray = 0;
   int idx = 0;
   bit prev_v = 0;
   int first_cyc = 0, acc_cyc = 0, first_mode = 0, first_addr = 0;
   bit chg = 0;
   int acc13 = -1;
   int ezq = 0;
   bit eibuf = 0;
   bit zq_bad = 0, ibuf_bad = 0, ld_bad = 0, done_bad = 0, extra_cmd = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         bit ewe, edone;
         if (valid && !prev_v) begin
            if (idx >= NSTEP) extra_cmd = 1;
            else begin
               check(int'(mode) == exp_mode(idx), "R2", $sformatf("mode of step %0d", idx), mode, exp_mode(idx));
               check(int'(addr) == exp_addr(idx), "R3", $sformatf("address of step %0d", idx), addr, exp_addr(idx));
               if (idx > 0)
                  check(cyc - acc_cyc - 1 == exp_gap(idx - 1), "R5", $sformatf("idle cycles before step %0d", idx),
                        cyc - acc_cyc - 1, exp_gap(idx - 1));
               first_cyc = cyc; first_mode = mode; first_addr = addr; chg = 0;
               if (idx == 3) ezq = 3;
               if (idx == 8) eibuf = 1;
            end
         end
         if (valid && prev_v && (int'(mode) != first_mode || int'(addr) != first_addr)) chg = 1;
         if (int'(zq) != ezq) zq_bad = 1;
         if (ibuf != eibuf) ibuf_bad = 1;
         ewe = (acc13 >= 0) && (cyc == acc13 + 2);
         if (ref_we != ewe || cal_we != ewe) ld_bad = 1;
         if (ewe && (ref_val != ref_cnt || cal_val != cal_cfg)) ld_bad = 1;
         edone = (acc13 >= 0) && (cyc >= acc13 + 3);
         if (done != edone) done_bad = 1;
         if (valid && idx < NSTEP) begin
            ack = (cyc - first_cyc >= lat);
            if (ack) begin
               check(cyc - first_cyc == lat && !chg, "R4", $sformatf("hold cycles of step %0d", idx),
                     cyc - first_cyc, lat);
               acc_cyc = cyc;
               if (idx == 3) ezq = 2;
               if (idx == 13) begin eibuf = 0; acc13 = cyc; end
               idx++;
            end
         end else begin
            ack = stray && (cyc % 5 == 2);
         end
         prev_v = valid;
      end
   end

   task automatic run(int l, bit s);
      int g;
      mon_on = 0; rst_n = 0; start = 0; ack = 0;
      ref_cnt = 16'h0400 + 16'(l); cal_cfg = 32'hA5C3_0000 | 32'(l);
      repeat (3) @(negedge clk);
      check(!valid && !ibuf && zq == 2'b00 && !done && !ref_we && !cal_we, "R1", "outputs in reset",
            {valid, ibuf, zq, done, ref_we, cal_we}, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      check(!valid && !ibuf && zq == 2'b00 && !done && !ref_we && !cal_we, "R1", "outputs idle after reset",
            {valid, ibuf, zq, done, ref_we, cal_we}, 0);
      lat = l; stray = s; idx = 0; prev_v = 0; acc13 = -1; ezq = 0; eibuf = 0;
      zq_bad = 0; ibuf_bad = 0; ld_bad = 0; done_bad = 0; extra_cmd = 0;
      mon_on = 1;
      start = 1;
      @(negedge clk) start = 0;
      if (s) begin
         wait (idx == 5);
         @(negedge clk) start = 1;
         @(negedge clk) start = 0;
      end
      g = 0;
      while (!done && g < 8000) begin
         @(negedge clk);
         g++;
      end
      check(done, "R9", "done reached before watchdog", done, 1);
      if (s) begin
         @(negedge clk) start = 1;
         @(negedge clk) start = 0;
      end
      repeat (30) @(negedge clk);
      check(idx == NSTEP, "R3", "commands accepted", idx, NSTEP);
      check(!extra_cmd, s ? "R10" : "R9", "command after sequence end", extra_cmd, 0);
      check(!zq_bad, "R6", "calibration type trace", zq_bad, 0);
      check(!ibuf_bad, "R7", "input-buffer trace", ibuf_bad, 0);
      check(!ld_bad, "R8", "load strobes and values", ld_bad, 0);
      check(!done_bad, "R9", "done trace", done_bad, 0);
      mon_on = 0;
   endtask

   initial begin
      for (int l = 0; l < 4; l++) begin
         for (int s = 0; s < 2; s++) begin
            run(l, s[0]);
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule